// File: doc/BRIEF.md
# Code Protection and Scrambled Verify Unit

This block guards the on-chip program store of a microcontroller. It keeps a 32-byte scrambling key table and two protection bits. Both are modelled as non-volatile cells whose erased value is all ones. A bulk-erase strobe stands in for the ultraviolet erase. Whenever the store is read out for verification, the unit XNORs the outgoing code byte with the key byte that the low five address bits select. A device whose key table is still erased therefore reads out in clear.

The two protection bits raise the level of protection step by step. Programming either bit closes all further programming of the code store and the key table, although the other protection bit can still be programmed. Protection bit 1 stops code fetched from external memory from reading internal program memory. It also makes the external-access strap a value latched at reset instead of a live pin. With both bits programmed, verification read-out is suppressed entirely. Programming bit 2 alone is a reserved combination and adds nothing. The key table has no read path at all.

Top module: `code_guard`

## Requirements
- R1: A cycle with `erase` high sets every key byte to 8'hFF and both protection cells to erased (`lock_prog` = 2'b00) from the next cycle on; with an erased key table `vfy_data` equals `vfy_code`.
- R2: While verification is allowed, `vfy_data` = ~(`vfy_code` ^ key[i]) in the same cycle, combinationally.
- R3: The key index i is `vfy_addr[4:0]`; higher address bits do not affect the key choice (address 16'h0025 uses key 5).
- R4: A key write (`key_wr_en` high, index `key_wr_idx` 0..31, byte `key_wr_data`) is stored at the next clock edge when `lock_prog` = 2'b00.
- R5: With protection bit 1 programmed (`lock_prog[0]` = 1), `int_code_ok` is low while `ext_fetch` is high, and high while `ext_fetch` is low.
- R6: With either protection bit programmed, `prog_allow` is low and key writes are ignored; a protection write (`lock_wr_en` high, `lock_wr_sel` 0 = bit 1, 1 = bit 2) still programs the other bit; programmed bits stay programmed until an erase.
- R7: With both bits programmed (`lock_prog` = 2'b11), `vfy_data` is 8'hFF whatever the address and code.
- R8: With only protection bit 2 programmed (`lock_prog` = 2'b10), verification still returns scrambled data and `int_code_ok` stays high while `ext_fetch` is high.
- R9: With protection bit 1 programmed, `ea_level` holds the `ext_access` value sampled in the last reset cycle and ignores later pin changes; with bit 1 unprogrammed, `ea_level` follows `ext_access` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; samples `ext_access` |
| erase | input | 1 | Bulk erase of key table and protection cells to ones |
| ext_access | input | 1 | External-access strap level |
| key_wr_en | input | 1 | Key table write strobe |
| key_wr_idx | input | 5 | Key table entry to write |
| key_wr_data | input | 8 | Key byte to write |
| lock_wr_en | input | 1 | Protection bit write strobe |
| lock_wr_sel | input | 1 | 0 selects protection bit 1, 1 selects bit 2 |
| ext_fetch | input | 1 | Current fetch comes from external program memory |
| vfy_addr | input | 16 | Verification read address |
| vfy_code | input | 8 | Code byte read from the store at `vfy_addr` |
| vfy_data | output | 8 | Scrambled or blanked verification byte |
| prog_allow | output | 1 | Code store and key table may be programmed |
| int_code_ok | output | 1 | Access to internal code is permitted |
| ea_level | output | 1 | Effective external-access level |
| lock_prog | output | 2 | Protection bits, 1 = programmed ([0] bit 1, [1] bit 2) |

## Verification
The properties assume that the storage has been bulk-erased at least once while reset is held, because the non-volatile cells carry no reset of their own. Before that erase their state is unknown. The bench therefore raises `erase` during its opening reset and repeats it between protection scenarios. The hold property on `ea_level` also takes for granted that reset is the only event that may move the latched strap. For this reason, the bench toggles `ext_access` only outside reset while it checks that the latched value holds.

// File: rtl/code_guard_pkg.sv
package code_guard_pkg;
    parameter int DATA_W    = 8;
    parameter int ADDR_W    = 16;
    parameter int KEY_DEPTH = 32;
    localparam int IDX_W    = $clog2(KEY_DEPTH);

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  kidx_t;

    typedef enum logic [1:0] {
        PROT_NONE     = 2'b00,
        PROT_ISOLATE  = 2'b01,
        PROT_RESERVED = 2'b10,
        PROT_FULL     = 2'b11
    } prot_e;

    typedef struct packed {
        logic  en;
        kidx_t idx;
        byte_t data;
    } key_wr_t;

    function automatic byte_t scramble(input byte_t code, input byte_t key);
        return ~(code ^ key);
    endfunction
endpackage

// File: rtl/cg_key_store.sv
module cg_key_store
    import code_guard_pkg::*;
(
    input  logic    clk,
    input  logic    erase,
    input  logic    wr_ok,
    input  key_wr_t wr,
    input  kidx_t   rd_idx,
    output byte_t   rd_key
);
    byte_t cells [KEY_DEPTH];

    generate
        for (genvar g = 0; g < KEY_DEPTH; g++) begin : g_cell
            always_ff @(posedge clk) begin
                if (erase)
                    cells[g] <= '1;
                else if (wr_ok && wr.en && wr.idx == kidx_t'(g))
                    cells[g] <= wr.data;
            end
        end
    endgenerate

    assign rd_key = cells[rd_idx];
endmodule

// File: rtl/cg_prot_ctrl.sv
module cg_prot_ctrl
    import code_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  erase,
    input  logic  lock_wr_en,
    input  logic  lock_wr_sel,
    input  logic  ext_access,
    input  logic  ext_fetch,
    output prot_e level,
    output logic  prog_ok,
    output logic  vfy_ok,
    output logic  int_ok,
    output logic  ea_eff
);
    logic [1:0] cell_q;
    logic       ea_q;

    always_ff @(posedge clk) begin
        if (erase)
            cell_q <= 2'b11;
        else if (lock_wr_en)
            cell_q[lock_wr_sel] <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ea_q <= ext_access;
    end

    assign level   = prot_e'(~cell_q);
    assign prog_ok = (level == PROT_NONE);
    assign vfy_ok  = (level != PROT_FULL);
    assign int_ok  = !(level[0] && ext_fetch);
    assign ea_eff  = level[0] ? ea_q : ext_access;
endmodule

// File: rtl/cg_vfy_path.sv
module cg_vfy_path
    import code_guard_pkg::*;
(
    input  logic  allow,
    input  byte_t code,
    input  byte_t key,
    output byte_t dout
);
    always_comb begin
        if (allow)
            dout = scramble(code, key);
        else
            dout = '1;
    end
endmodule

// File: rtl/code_guard.sv
module code_guard
    import code_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              erase,
    input  logic              ext_access,
    input  logic              key_wr_en,
    input  logic [IDX_W-1:0]  key_wr_idx,
    input  logic [DATA_W-1:0] key_wr_data,
    input  logic              lock_wr_en,
    input  logic              lock_wr_sel,
    input  logic              ext_fetch,
    input  logic [ADDR_W-1:0] vfy_addr,
    input  logic [DATA_W-1:0] vfy_code,
    output logic [DATA_W-1:0] vfy_data,
    output logic              prog_allow,
    output logic              int_code_ok,
    output logic              ea_level,
    output logic [1:0]        lock_prog
);
    key_wr_t wr;
    prot_e   level;
    logic    vfy_ok;
    byte_t   key_sel;

    assign wr = '{en: key_wr_en, idx: key_wr_idx, data: key_wr_data};

    cg_prot_ctrl u_prot (
        .clk        (clk),
        .rst        (rst),
        .erase      (erase),
        .lock_wr_en (lock_wr_en),
        .lock_wr_sel(lock_wr_sel),
        .ext_access (ext_access),
        .ext_fetch  (ext_fetch),
        .level      (level),
        .prog_ok    (prog_allow),
        .vfy_ok     (vfy_ok),
        .int_ok     (int_code_ok),
        .ea_eff     (ea_level)
    );

    cg_key_store u_keys (
        .clk   (clk),
        .erase (erase),
        .wr_ok (prog_allow),
        .wr    (wr),
        .rd_idx(vfy_addr[IDX_W-1:0]),
        .rd_key(key_sel)
    );

    cg_vfy_path u_vfy (
        .allow(vfy_ok),
        .code (vfy_code),
        .key  (key_sel),
        .dout (vfy_data)
    );

    assign lock_prog = level;
endmodule

// File: rtl/code_guard_chk.sv
module code_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       erase,
    input logic       ext_access,
    input logic       ext_fetch,
    input logic [7:0] vfy_data,
    input logic       prog_allow,
    input logic       int_code_ok,
    input logic       ea_level,
    input logic [1:0] lock_prog
);
    // R1
    p_erase_clears_r1: assert property (@(posedge clk)
        erase |=> lock_prog == 2'b00);

    // R6
    p_prog_closed_r6: assert property (@(posedge clk) disable iff (rst)
        (lock_prog != 2'b00) |-> !prog_allow);

    // R6: a programmed bit only clears through erase
    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (lock_prog[0] && !erase) |=> lock_prog[0]);

    // R7
    p_vfy_blank_r7: assert property (@(posedge clk) disable iff (rst)
        (lock_prog == 2'b11) |-> vfy_data == 8'hFF);

    // R5
    p_ext_isolated_r5: assert property (@(posedge clk) disable iff (rst)
        (lock_prog[0] && ext_fetch) |-> !int_code_ok);

    // R9
    p_ea_held_r9: assert property (@(posedge clk) disable iff (rst)
        (lock_prog[0] && $past(lock_prog[0]) && !$past(rst)) |-> $stable(ea_level));
endmodule

bind code_guard code_guard_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .erase      (erase),
    .ext_access (ext_access),
    .ext_fetch  (ext_fetch),
    .vfy_data   (vfy_data),
    .prog_allow (prog_allow),
    .int_code_ok(int_code_ok),
    .ea_level   (ea_level),
    .lock_prog  (lock_prog)
);

// File: tb/tb_code_guard.sv
module tb_code_guard;
    logic        clk = 1'b0;
    logic        rst, erase, ext_access, key_wr_en, lock_wr_en, lock_wr_sel, ext_fetch;
    logic [4:0]  key_wr_idx;
    logic [7:0]  key_wr_data, vfy_code, vfy_data;
    logic [15:0] vfy_addr;
    logic        prog_allow, int_code_ok, ea_level;
    logic [1:0]  lock_prog;

    int errors = 0;
    int checks = 0;
    logic [7:0] km [32];

    always #2 clk = ~clk;

    code_guard dut (
        .clk(clk), .rst(rst), .erase(erase), .ext_access(ext_access),
        .key_wr_en(key_wr_en), .key_wr_idx(key_wr_idx), .key_wr_data(key_wr_data),
        .lock_wr_en(lock_wr_en), .lock_wr_sel(lock_wr_sel), .ext_fetch(ext_fetch),
        .vfy_addr(vfy_addr), .vfy_code(vfy_code), .vfy_data(vfy_data),
        .prog_allow(prog_allow), .int_code_ok(int_code_ok), .ea_level(ea_level),
        .lock_prog(lock_prog)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  c;
        logic [7:0]  e;
    } vec_t;

    // stimulus with the result expected from an erased key table
    localparam vec_t VECS [8] = '{
        '{16'h0000, 8'h3C, 8'h3C}, '{16'h0001, 8'hA5, 8'hA5},
        '{16'h001F, 8'h00, 8'h00}, '{16'h0020, 8'hFF, 8'hFF},
        '{16'h0025, 8'h5A, 8'h5A}, '{16'h1234, 8'h81, 8'h81},
        '{16'hABCD, 8'h7E, 8'h7E}, '{16'hFFFF, 8'hC3, 8'hC3}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic probe(input logic [15:0] a, input logic [7:0] c);
        vfy_addr = a;
        vfy_code = c;
        #1;
    endtask

    task automatic prog_lock(input logic sel);
        lock_wr_en = 1'b1; lock_wr_sel = sel;
        step();
        lock_wr_en = 1'b0;
    endtask

    task automatic do_erase();
        erase = 1'b1;
        step();
        erase = 1'b0;
        for (int i = 0; i < 32; i++) km[i] = 8'hFF;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; erase = 1'b1; ext_access = 1'b0;
        key_wr_en = 1'b0; key_wr_idx = '0; key_wr_data = '0;
        lock_wr_en = 1'b0; lock_wr_sel = 1'b0; ext_fetch = 1'b0;
        vfy_addr = '0; vfy_code = '0;
        for (int i = 0; i < 32; i++) km[i] = 8'hFF;
        step(); step();
        erase = 1'b0;
        step();
        rst = 1'b0;
        step();

        // reset / erased state
        chk("R1 lock_prog after erase", {6'd0, lock_prog}, 8'h00);
        chk("R6 prog_allow when open", {7'd0, prog_allow}, 8'h01);
        chk("R9 ea follows pin (0)", {7'd0, ea_level}, 8'h00);
        ext_access = 1'b1; #1;
        chk("R9 ea follows pin (1)", {7'd0, ea_level}, 8'h01);

        // erased key table passes data through
        for (int v = 0; v < 8; v++) begin
            probe(VECS[v].a, VECS[v].c);
            chk("R1 erased passthrough", vfy_data, VECS[v].e);
        end

        // program the whole key table
        for (int i = 0; i < 32; i++) begin
            key_wr_en = 1'b1; key_wr_idx = 5'(i); key_wr_data = 8'(i * 37 + 5);
            km[i] = 8'(i * 37 + 5);
            step();
        end
        key_wr_en = 1'b0;

        for (int v = 0; v < 8; v++) begin
            probe(VECS[v].a, VECS[v].c);
            chk("R2 R4 scrambled verify", vfy_data, ~(VECS[v].c ^ km[VECS[v].a[4:0]]));
        end
        probe(16'h0025, 8'h00);
        chk("R3 addr 0x25 uses key 5", vfy_data, ~km[5]);
        probe(16'hFFE0, 8'hFF);
        chk("R3 addr 0xFFE0 uses key 0", vfy_data, km[0]);

        // protection bit 2 alone (reserved)
        prog_lock(1'b1);
        chk("R6 bit2 programmed", {6'd0, lock_prog}, 8'h02);
        chk("R6 prog closed by bit2", {7'd0, prog_allow}, 8'h00);
        key_wr_en = 1'b1; key_wr_idx = 5'd3; key_wr_data = 8'h00;
        step();
        key_wr_en = 1'b0;
        probe(16'h0003, 8'h96);
        chk("R6 key write ignored", vfy_data, ~(8'h96 ^ km[3]));
        chk("R8 verify still scrambled", vfy_data, ~(8'h96 ^ km[3]));
        ext_fetch = 1'b1; #1;
        chk("R8 internal access kept", {7'd0, int_code_ok}, 8'h01);
        ext_fetch = 1'b0;

        // other bit still programmable -> full protection
        prog_lock(1'b0);
        chk("R6 second bit programmed", {6'd0, lock_prog}, 8'h03);
        probe(16'h0007, 8'h12);
        chk("R7 verify blanked", vfy_data, 8'hFF);
        probe(16'h8000, 8'h00);
        chk("R7 verify blanked 2", vfy_data, 8'hFF);

        // bit 1 alone, strap latch
        do_erase();
        chk("R1 erase reopens", {6'd0, lock_prog}, 8'h00);
        probe(16'h0003, 8'h96);
        chk("R1 key erased", vfy_data, 8'h96);
        ext_access = 1'b0;
        rst = 1'b1; step(); rst = 1'b0;
        prog_lock(1'b0);
        chk("R6 bit1 programmed", {6'd0, lock_prog}, 8'h01);
        chk("R6 prog closed by bit1", {7'd0, prog_allow}, 8'h00);
        ext_fetch = 1'b1; #1;
        chk("R5 external fetch blocked", {7'd0, int_code_ok}, 8'h00);
        ext_fetch = 1'b0; #1;
        chk("R5 internal fetch allowed", {7'd0, int_code_ok}, 8'h01);
        ext_access = 1'b1;
        step();
        chk("R9 latched strap holds 0", {7'd0, ea_level}, 8'h00);
        rst = 1'b1; step(); rst = 1'b0; step();
        chk("R9 relatched strap 1", {7'd0, ea_level}, 8'h01);
        ext_access = 1'b0; step();
        chk("R9 latched strap holds 1", {7'd0, ea_level}, 8'h01);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule